// File: doc/BRIEF.md
# Banked Exception Pending Controller

This block keeps the pending state of a small exception controller in two banks. One bank is the default, non-secure one. The other is a secure bank that exists only for a fixed set of banked exception numbers. Pend and clear requests arrive from four places: a control/state register write that carries a secure attribute, a software-trigger register write, level inputs for external interrupts, and a numbered request port used by fault logic. Each request names its bank. A secure request for an exception that has no secure copy is refused and reported.

A synchronous fault that cannot be taken is flagged by the requester on the request port. The block then pends the hard fault in place of that fault. It picks the hard-fault bank from the security of the original request and a configuration bit that routes hard faults to the non-secure side. Every such redirect sets one forced-escalation flag, which both banks share. A two-state machine (REQ_QUIET, REQ_RAISED) drives a single exception-request line. The RAISE transition is taken when some pending bit is also enabled, and the DROP transition is taken when none is left. Priority, activation and vector fetch belong to other blocks, and the enables arrive as plain inputs.

Exception numbering: 1 reset, 2 non-maskable, 3 hard fault, 3..13 synchronous faults, 14 deferred service call, 15 system timer, and 16 and up external interrupts. The banked numbers are 3, 4, 6, 11, 14 and 15.

Top module: `xcp_pend_ctrl`

## Requirements
- R1: A request on the numbered port with a number of 1 or less, or a number of NUM_EXC or more, changes no state and raises no error.
- R2: Non-secure requests, and requests for non-banked numbers, act on the non-secure bank. Secure requests for the banked numbers 3, 4, 6, 11, 14 and 15 act on the secure bank only.
- R3: A secure request for a non-banked number pulses bank_err in the cycle after the request and changes no pending bit.
- R4: A clear request alters only a bit that is set. Clearing a bit that is not set leaves both banks unchanged.
- R5: Writing csr_wdata bit 31 pends number 2 in the non-secure bank, whatever the value of csr_secure.
- R6: In a control/state write, bit 28 pends 14 and bit 27 clears it, and bit 26 pends 15 and bit 25 clears it. In each pair the set bit wins, and the clear acts only when the set bit is 0. csr_secure picks the bank.
- R7: A software-trigger write pends number trig_wdata[8:0]+16 in the non-secure bank when that number is below NUM_EXC. Otherwise it is ignored.
- R8: External input i pends number 16+i in the non-secure bank only when its level changes to high. A level that stays high does not pend again.
- R9: A set request with req_escalate for a number from 3 to 13 pends hard fault 3 instead. The secure copy is used when the extension is present and either req_secure is 1 or hf_ns_cfg is 0. Otherwise the non-secure copy is used.
- R10: Each escalation sets hf_forced. The flag is shared by both banks and stays set until reset.
- R11: exc_req is high in the cycle after some bit of either bank is both pending and enabled, and it is low in the cycle after none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Control/state register write strobe |
| csr_wdata | input | 32 | Control/state write data |
| csr_secure | input | 1 | Secure attribute of the control/state write |
| trig_we | input | 1 | Software-trigger write strobe |
| trig_wdata | input | 9 | Software-trigger offset from number 16 |
| ext_irq | input | NUM_EXC-16 | External interrupt levels |
| req_valid | input | 1 | Numbered request strobe |
| req_set | input | 1 | 1 pend, 0 clear |
| req_num | input | $clog2(NUM_EXC) | Exception number of the request |
| req_secure | input | 1 | Request targets the secure bank |
| req_escalate | input | 1 | Fault cannot be taken (disabled or too low in priority) |
| hf_ns_cfg | input | 1 | Route hard faults to the non-secure bank |
| en_ns | input | NUM_EXC | Enables of the non-secure bank |
| en_s | input | NUM_EXC | Enables of the secure bank |
| pend_ns | output | NUM_EXC | Pending bits of the non-secure bank |
| pend_s | output | NUM_EXC | Pending bits of the secure bank (0 where not banked) |
| hf_forced | output | 1 | Shared forced-escalation flag |
| bank_err | output | 1 | Illegal secure request seen in the previous cycle |
| exc_req | output | 1 | Exception request line |

## Verification
The control/state write is driven with single set bits, set and clear bits together, and clears of bits that are not set, all under both security attributes. This separates set priority, the bank choice and the rule that a clear touches only a set bit. Software triggers are placed on both sides of the top of the range. External lines are held high and then toggled, which tells an edge response from a level response. Escalations run through the combinations of request security and routing bit, with a number in the synchronous range against one outside it, so that a wrong bank choice or a missing forced flag shows up. Enables are turned on and off around pending bits to check the one-cycle lag of the request line.

// File: rtl/xcp_pend_pkg.sv
package xcp_pend_pkg;

    localparam int EXC_NMI    = 2;
    localparam int EXC_HARD   = 3;
    localparam int EXC_DSVC   = 14;
    localparam int EXC_TIMER  = 15;
    localparam int EXC_EXT0   = 16;

    typedef enum logic {
        REQ_QUIET,
        REQ_RAISED
    } req_state_e;

    function automatic logic is_banked(input int n);
        return (n == 3) || (n == 4) || (n == 6) || (n == 11) || (n == 14) || (n == 15);
    endfunction

endpackage

// File: rtl/xcp_edge_det.sv
module xcp_edge_det #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

endmodule

// File: rtl/xcp_req_route.sv
module xcp_req_route
    import xcp_pend_pkg::*;
#(
    parameter int NUM_EXC = 48,
    parameter bit SEC_EXT = 1'b1,
    localparam int EW = $clog2(NUM_EXC)
) (
    input  logic               req_valid,
    input  logic               req_set,
    input  logic [EW-1:0]      req_num,
    input  logic               req_secure,
    input  logic               req_escalate,
    input  logic               hf_ns_cfg,
    output logic [NUM_EXC-1:0] set_ns,
    output logic [NUM_EXC-1:0] set_s,
    output logic [NUM_EXC-1:0] clr_ns,
    output logic [NUM_EXC-1:0] clr_s,
    output logic               bad_bank,
    output logic               force_hf
);
    logic sec;
    logic in_range;
    logic banked;
    logic sync_fault;
    int   num;

    always_comb begin
        num        = int'(req_num);
        sec        = req_secure && SEC_EXT;
        in_range   = (num > 1) && (num < NUM_EXC);
        banked     = is_banked(num);
        sync_fault = (num >= EXC_HARD) && (num < EXC_DSVC);
        set_ns     = '0;
        set_s      = '0;
        clr_ns     = '0;
        clr_s      = '0;
        bad_bank   = 1'b0;
        force_hf   = 1'b0;
        if (req_valid && in_range) begin
            if (sec && !banked) begin
                bad_bank = 1'b1;
            end else if (req_set && req_escalate && sync_fault) begin
                force_hf = 1'b1;
                if (SEC_EXT && (sec || !hf_ns_cfg)) set_s[EXC_HARD]  = 1'b1;
                else                                set_ns[EXC_HARD] = 1'b1;
            end else begin
                for (int i = 0; i < NUM_EXC; i++) begin
                    if (num == i) begin
                        if (req_set) begin
                            if (sec) set_s[i]  = 1'b1;
                            else     set_ns[i] = 1'b1;
                        end else begin
                            if (sec) clr_s[i]  = 1'b1;
                            else     clr_ns[i] = 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/xcp_pend_ctrl.sv
module xcp_pend_ctrl
    import xcp_pend_pkg::*;
#(
    parameter int NUM_EXC = 48,
    parameter bit SEC_EXT = 1'b1,
    localparam int EW      = $clog2(NUM_EXC),
    localparam int NUM_EXT = NUM_EXC - EXC_EXT0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [31:0]        csr_wdata,
    input  logic               csr_secure,
    input  logic               trig_we,
    input  logic [8:0]         trig_wdata,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic               req_valid,
    input  logic               req_set,
    input  logic [EW-1:0]      req_num,
    input  logic               req_secure,
    input  logic               req_escalate,
    input  logic               hf_ns_cfg,
    input  logic [NUM_EXC-1:0] en_ns,
    input  logic [NUM_EXC-1:0] en_s,
    output logic [NUM_EXC-1:0] pend_ns,
    output logic [NUM_EXC-1:0] pend_s,
    output logic               hf_forced,
    output logic               bank_err,
    output logic               exc_req
);
    logic [NUM_EXC-1:0] r_set_ns, r_set_s, r_clr_ns, r_clr_s;
    logic [NUM_EXC-1:0] set_ns, set_s, clr_ns, clr_s;
    logic [NUM_EXT-1:0] rise;
    logic               bad_bank, force_hf, csr_sec, any_live;
    logic [9:0]         trig_num;
    logic               unused_csr;
    req_state_e         state_q, state_d;

    assign unused_csr = ^{csr_wdata[30:29], csr_wdata[24:0]};

    xcp_edge_det #(.WIDTH(NUM_EXT)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (ext_irq),
        .rise (rise)
    );

    xcp_req_route #(.NUM_EXC(NUM_EXC), .SEC_EXT(SEC_EXT)) u_route (
        .req_valid   (req_valid),
        .req_set     (req_set),
        .req_num     (req_num),
        .req_secure  (req_secure),
        .req_escalate(req_escalate),
        .hf_ns_cfg   (hf_ns_cfg),
        .set_ns      (r_set_ns),
        .set_s       (r_set_s),
        .clr_ns      (r_clr_ns),
        .clr_s       (r_clr_s),
        .bad_bank    (bad_bank),
        .force_hf    (force_hf)
    );

    // Merge all sources into per-bank set and clear vectors.
    always_comb begin
        csr_sec  = csr_secure && SEC_EXT;
        trig_num = {1'b0, trig_wdata} + 10'(EXC_EXT0);
        set_ns   = r_set_ns;
        set_s    = r_set_s;
        clr_ns   = r_clr_ns;
        clr_s    = r_clr_s;
        for (int i = 0; i < NUM_EXT; i++) begin
            if (rise[i]) set_ns[EXC_EXT0 + i] = 1'b1;
        end
        for (int i = EXC_EXT0; i < NUM_EXC; i++) begin
            if (trig_we && (trig_num == 10'(i))) set_ns[i] = 1'b1;
        end
        if (csr_we) begin
            if (csr_wdata[31]) set_ns[EXC_NMI] = 1'b1;
            if (csr_wdata[28]) begin
                if (csr_sec) set_s[EXC_DSVC]  = 1'b1;
                else         set_ns[EXC_DSVC] = 1'b1;
            end else if (csr_wdata[27]) begin
                if (csr_sec) clr_s[EXC_DSVC]  = 1'b1;
                else         clr_ns[EXC_DSVC] = 1'b1;
            end
            if (csr_wdata[26]) begin
                if (csr_sec) set_s[EXC_TIMER]  = 1'b1;
                else         set_ns[EXC_TIMER] = 1'b1;
            end else if (csr_wdata[25]) begin
                if (csr_sec) clr_s[EXC_TIMER]  = 1'b1;
                else         clr_ns[EXC_TIMER] = 1'b1;
            end
        end
    end

    // Pending storage: non-secure bits from 2 upward, secure bits only where banked.
    for (genvar g = 0; g < NUM_EXC; g++) begin : g_bit
        if (g > 1) begin : g_ns
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      pend_ns[g] <= 1'b0;
                else if (set_ns[g])              pend_ns[g] <= 1'b1;
                else if (clr_ns[g] && pend_ns[g]) pend_ns[g] <= 1'b0;
            end
        end else begin : g_ns_none
            assign pend_ns[g] = 1'b0;
        end
        if (SEC_EXT && is_banked(g)) begin : g_s
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                    pend_s[g] <= 1'b0;
                else if (set_s[g])             pend_s[g] <= 1'b1;
                else if (clr_s[g] && pend_s[g]) pend_s[g] <= 1'b0;
            end
        end else begin : g_s_none
            assign pend_s[g] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hf_forced <= 1'b0;
            bank_err  <= 1'b0;
        end else begin
            bank_err <= bad_bank;
            if (force_hf) hf_forced <= 1'b1;
        end
    end

    // Request line state machine: RAISE when something live, DROP when nothing.
    assign any_live = |(pend_ns & en_ns) || |(pend_s & en_s);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_QUIET:  if (any_live)  state_d = REQ_RAISED;
            REQ_RAISED: if (!any_live) state_d = REQ_QUIET;
            default:                   state_d = REQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        exc_req = (state_q == REQ_RAISED);
    end

    AST_ERR_FROM_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_err |-> $past(req_valid && req_secure)); // R3

    AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_err && !$past(csr_we || trig_we || (|rise)))
            |-> (pend_ns == $past(pend_ns) && pend_s == $past(pend_s))); // R3

    AST_FORCED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(hf_forced)); // R10

    AST_FORCED_WITH_HF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hf_forced) |-> (pend_ns[EXC_HARD] || pend_s[EXC_HARD])); // R9

    AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past((|pend_ns) || (|pend_s))); // R11

endmodule

// File: tb/xcp_pend_ctrl_test.sv
module xcp_pend_ctrl_test;
    localparam int N  = 48;
    localparam int NX = N - 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 0, csr_secure = 0, trig_we = 0;
    logic [31:0]   csr_wdata = '0;
    logic [8:0]    trig_wdata = '0;
    logic [NX-1:0] ext_irq = '0;
    logic          req_valid = 0, req_set = 0, req_secure = 0, req_escalate = 0, hf_ns_cfg = 0;
    logic [5:0]    req_num = '0;
    logic [N-1:0]  en_ns = '0, en_s = '0;
    logic [N-1:0]  pend_ns, pend_s;
    logic          hf_forced, bank_err, exc_req;

    xcp_pend_ctrl uut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_secure(csr_secure), .trig_we(trig_we), .trig_wdata(trig_wdata),
        .ext_irq(ext_irq), .req_valid(req_valid), .req_set(req_set),
        .req_num(req_num), .req_secure(req_secure), .req_escalate(req_escalate),
        .hf_ns_cfg(hf_ns_cfg), .en_ns(en_ns), .en_s(en_s), .pend_ns(pend_ns),
        .pend_s(pend_s), .hf_forced(hf_forced), .bank_err(bank_err), .exc_req(exc_req)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [N-1:0] ns;
        logic [N-1:0] s;
        logic         forced;
        logic         err;
        logic         req;
        string        tag;
    } item_t;

    item_t        sb[$];
    int           compared = 0, mismatched = 0;
    logic [N-1:0] mns = '0, ms = '0;
    logic         mforced = 1'b0;
    logic [NX-1:0] mprev = '0;

    function automatic logic banked(input int n);
        return n == 3 || n == 4 || n == 6 || n == 11 || n == 14 || n == 15;
    endfunction

    task automatic check(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: build the expected result of the stimulus now on the pins, queue it, advance one cycle.
    task automatic commit(input string tag);
        item_t        it;
        logic [N-1:0] sn, ss, cn, cs;
        logic         err;
        int           num;
        sn = '0; ss = '0; cn = '0; cs = '0; err = 1'b0;
        it.req = |(mns & en_ns) || |(ms & en_s);
        for (int i = 0; i < NX; i++) if (ext_irq[i] && !mprev[i]) sn[16 + i] = 1'b1;
        mprev = ext_irq;
        if (trig_we && (int'(trig_wdata) + 16 < N)) sn[int'(trig_wdata) + 16] = 1'b1;
        if (csr_we) begin
            if (csr_wdata[31]) sn[2] = 1'b1;
            if (csr_wdata[28]) begin if (csr_secure) ss[14] = 1'b1; else sn[14] = 1'b1; end
            else if (csr_wdata[27]) begin if (csr_secure) cs[14] = 1'b1; else cn[14] = 1'b1; end
            if (csr_wdata[26]) begin if (csr_secure) ss[15] = 1'b1; else sn[15] = 1'b1; end
            else if (csr_wdata[25]) begin if (csr_secure) cs[15] = 1'b1; else cn[15] = 1'b1; end
        end
        num = int'(req_num);
        if (req_valid && num > 1 && num < N) begin
            if (req_secure && !banked(num)) err = 1'b1;
            else if (req_set && req_escalate && num >= 3 && num <= 13) begin
                mforced = 1'b1;
                if (req_secure || !hf_ns_cfg) ss[3] = 1'b1; else sn[3] = 1'b1;
            end else if (req_set) begin
                if (req_secure) ss[num] = 1'b1; else sn[num] = 1'b1;
            end else begin
                if (req_secure) cs[num] = 1'b1; else cn[num] = 1'b1;
            end
        end
        mns = (mns & ~cn) | sn;
        ms  = (ms & ~cs) | ss;
        it.ns = mns; it.s = ms; it.forced = mforced; it.err = err; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        csr_we = 0; trig_we = 0; req_valid = 0;
    endtask

    task automatic csr(input logic [31:0] d, input logic sec, input string tag);
        csr_we = 1; csr_wdata = d; csr_secure = sec; commit(tag);
    endtask

    task automatic trig(input logic [8:0] d, input string tag);
        trig_we = 1; trig_wdata = d; commit(tag);
    endtask

    task automatic req(input logic set, input int num, input logic sec, input logic esc, input string tag);
        req_valid = 1; req_set = set; req_num = 6'(num); req_secure = sec; req_escalate = esc; commit(tag);
    endtask

    // Monitor: compare each queued item shortly after the edge that produced it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, "pend_ns", pend_ns, it.ns);
                check(it.tag, "pend_s", pend_s, it.s);
                check("R10", "hf_forced", N'(hf_forced), N'(it.forced));
                check("R3", "bank_err", N'(bank_err), N'(it.err));
                check("R11", "exc_req", N'(exc_req), N'(it.req));
            end
        end
    end

    initial begin
        #4000000;
        compared++; mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset pend_ns", pend_ns, '0);
        check("R1", "reset pend_s", pend_s, '0);
        check("R11", "reset exc_req", N'(exc_req), '0);
        check("R10", "reset hf_forced", N'(hf_forced), '0);
        // R5: bit 31 always non-secure
        csr(32'h8000_0000, 1'b1, "R5");
        // R6: secure set, set beats clear, secure clear
        csr(32'h1000_0000, 1'b1, "R6");
        csr(32'h1800_0000, 1'b0, "R6");
        csr(32'h0800_0000, 1'b1, "R6");
        // R4: clear of a bit that is not set
        csr(32'h0200_0000, 1'b1, "R4");
        csr(32'h0400_0000, 1'b0, "R6");
        csr(32'h0600_0000, 1'b1, "R6");
        // R7: software trigger, in range, out of range, top
        trig(9'd5, "R7");
        trig(9'd40, "R7");
        trig(9'd31, "R7");
        trig(9'd32, "R7");
        // R8: edge-sensitive external lines
        ext_irq[3] = 1'b1; commit("R8");
        commit("R8");
        req(1'b0, 19, 1'b0, 1'b0, "R4");
        commit("R8");
        ext_irq[3] = 1'b0; commit("R8");
        ext_irq[3] = 1'b1; commit("R8");
        // R1: out-of-range numbers
        req(1'b1, 1, 1'b0, 1'b0, "R1");
        req(1'b1, 0, 1'b1, 1'b0, "R1");
        req(1'b1, 48, 1'b0, 1'b0, "R1");
        req(1'b1, 63, 1'b1, 1'b0, "R1");
        req(1'b0, 47, 1'b0, 1'b0, "R4");
        // R3: secure requests on non-banked numbers
        req(1'b1, 5, 1'b1, 1'b0, "R3");
        req(1'b1, 2, 1'b1, 1'b0, "R3");
        req(1'b0, 21, 1'b1, 1'b0, "R3");
        // R2: bank isolation
        req(1'b1, 4, 1'b1, 1'b0, "R2");
        req(1'b1, 4, 1'b0, 1'b0, "R2");
        req(1'b0, 4, 1'b1, 1'b0, "R2");
        // R9: escalation bank choice
        hf_ns_cfg = 1'b0; req(1'b1, 5, 1'b0, 1'b1, "R9");
        req(1'b0, 3, 1'b1, 1'b0, "R9");
        hf_ns_cfg = 1'b1; req(1'b1, 6, 1'b0, 1'b1, "R9");
        req(1'b1, 6, 1'b1, 1'b1, "R9");
        req(1'b1, 14, 1'b1, 1'b1, "R9");
        req(1'b1, 5, 1'b1, 1'b1, "R3");
        // R10: flag stays after the hard faults are cleared
        req(1'b0, 3, 1'b0, 1'b0, "R10");
        req(1'b0, 3, 1'b1, 1'b0, "R10");
        // R11: request line follows pending and enabled
        en_ns[21] = 1'b1; commit("R11");
        commit("R11");
        req(1'b0, 21, 1'b0, 1'b0, "R11");
        commit("R11");
        en_ns = '0; en_s[4] = 1'b1; commit("R11");
        en_s = '0; commit("R11");
        commit("R11");
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule